// File: doc/BRIEF.md
# Vectored Interrupt Enable/Pending Controller

This block collects up to 32 interrupt request lines and turns them into a single prioritised request toward a processor core. Each line has an enable bit, a pending bit, an active bit and a two-bit priority. Software reaches them through a small register bus. Enable and pending state each have their own set register and clear register. A write of 1 to a bit changes that line, and a write of 0 leaves it as it was. The active state can only be read.

A rising edge on a request input latches the line as pending, whether or not the line is enabled. The arbiter looks at every line that is pending, enabled and more urgent than the core's current-priority mask. It presents the winner's number and a request. When the core acknowledges, the line moves from pending to active, and an end-of-service strobe carrying the line number retires it. One line can be chosen as the non-maskable source. Its input level then drives a dedicated output, it takes no part in normal arbitration, and while that output is high the normal request is held low.

Top module: `irq_ctrl`

## Requirements
- R1: A write to address 0 sets the enable bit of every line whose data bit is 1, and data bits at 0 change nothing. Reads of address 0 and of address 1 both return the enable vector, bit i for line i.
- R2: A write to address 1 clears the enable bit of every line whose data bit is 1, and data bits at 0 change nothing.
- R3: A write to address 2 sets pending bits and a write to address 3 clears them, with 1 acting and 0 doing nothing. Reads of address 2 and of address 3 return the pending vector.
- R4: A 0-to-1 transition of `irqIn[i]`, seen between two clock edges, makes line i pending on the second edge, whatever the state of its enable bit. An input that stays high does not set the line pending again after it has been cleared.
- R5: Address 4 returns the active vector. Writes to address 4 have no effect.
- R6: Line i has a priority field at bits [2*(i%16)+1 : 2*(i%16)] of address 5 + i/16, and 0 is the most urgent value. Among lines that are pending and enabled, `irqReq`/`irqId` name the line with the numerically smallest priority. The outputs follow the register state combinationally.
- R7: When two or more candidate lines share the smallest priority value, the line with the lowest number is presented.
- R8: A line is only presented when its priority value is strictly less than `prioMask`. A mask of 0 blocks every line and a mask of 4 lets every line through.
- R9: When `irqAck` is high while `irqReq` is high, the next edge clears the pending bit and sets the active bit of the line shown on `irqId`. When `irqReq` is low, `irqAck` is ignored.
- R10: An `eoiValid` strobe clears the active bit of line `eoiId` on the next edge. If an acknowledge of that same line happens in the same cycle, the active bit ends up set.
- R11: If a rising edge on a line's input falls in the same cycle as that line's acknowledge or a clear-pending write to it, the line remains pending.
- R12: Address 7 holds the non-maskable selection: bit 5 is the enable and bits [4:0] are the line number. While it is enabled, `nmiOut` shows the selected input's level, registered by one clock edge. The selected line is never presented on `irqReq`, and `irqReq` is low whenever `nmiOut` is high.
- R13: After reset, every enable, pending, active, priority and selection bit is 0, and `irqReq` and `nmiOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqIn | input | 32 | Interrupt request inputs, latched on rising edge |
| prioMask | input | 3 | Current-priority mask from the core |
| irqReq | output | 1 | A line is being presented |
| irqId | output | 5 | Number of the presented line |
| irqAck | input | 1 | Core takes the presented line |
| eoiValid | input | 1 | End of service strobe |
| eoiId | input | 5 | Line whose service ends |
| nmiOut | output | 1 | Non-maskable request |

## Verification
The collision that matters most is a fresh rising edge on a line in the same cycle that the line's pending bit is being removed, whether by the core's acknowledge or by a software clear. The bench provokes both cases on purpose. It raises the input in the acknowledge cycle, and in a second case it raises the input together with a clear-pending write. After each, it reads the pending register, and the edge must win. The acknowledge-with-end-of-service case on one line is driven and judged in the same way against the active register. A long randomised phase then lets all of these coincide freely, while a behavioural model is compared with the outputs and the read data on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int PRIO_WORD_W = 4;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic                   setEn;
    logic                   clrEn;
    logic                   setPend;
    logic                   clrPend;
    logic                   prioWr;
    logic                   nmiWr;
    logic                   ack;
    logic                   eoi;
    logic [PRIO_WORD_W-1:0] prioWord;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_ctrl_ctrl.sv
module irq_ctrl_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PRIO_BASE  = 5,
  parameter int PRIO_WORDS = 2,
  parameter int NMI_ADDR   = 7
) (
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              irqAck,
  input  logic              irqReq,
  input  logic              eoiValid,
  output ctrlStrobes_t      strobes
);

  localparam logic [ADDR_W-1:0] A_SET_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET_PEND = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR_PEND = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PRIO_LO  = ADDR_W'(PRIO_BASE);
  localparam logic [ADDR_W-1:0] A_PRIO_HI  = ADDR_W'(PRIO_BASE + PRIO_WORDS);
  localparam logic [ADDR_W-1:0] A_NMI      = ADDR_W'(NMI_ADDR);

  logic [ADDR_W-1:0] wordOff;

  assign wordOff = busAddr - A_PRIO_LO;

  always_comb begin
    strobes          = '0;
    strobes.setEn    = busWr && (busAddr == A_SET_EN);
    strobes.clrEn    = busWr && (busAddr == A_CLR_EN);
    strobes.setPend  = busWr && (busAddr == A_SET_PEND);
    strobes.clrPend  = busWr && (busAddr == A_CLR_PEND);
    strobes.prioWr   = busWr && (busAddr >= A_PRIO_LO) && (busAddr < A_PRIO_HI);
    strobes.nmiWr    = busWr && (busAddr == A_NMI);
    strobes.prioWord = PRIO_WORD_W'(wordOff);
    // acknowledge only counts while a line is presented (R9)
    strobes.ack      = irqAck && irqReq;
    strobes.eoi      = eoiValid;
  end

endmodule

// File: rtl/irq_ctrl_datapath.sv
module irq_ctrl_datapath
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int PRIO_BITS  = 2,
  parameter int ADDR_W     = 4,
  parameter int PRIO_BASE  = 5,
  parameter int NMI_ADDR   = 7,
  localparam int ID_W      = $clog2(NUM_LINES),
  localparam int LPW       = NUM_LINES / PRIO_BITS,
  localparam int PRIO_WORDS = (NUM_LINES + LPW - 1) / LPW
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [NUM_LINES-1:0]           wdata,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [NUM_LINES-1:0]           irqIn,
  input  logic [ID_W-1:0]                ackId,
  input  logic [ID_W-1:0]                eoiId,
  output logic [NUM_LINES-1:0]           enQ,
  output logic [NUM_LINES-1:0]           pendQ,
  output logic [NUM_LINES-1:0]           actQ,
  output logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  output logic [NUM_LINES-1:0]           nmiLineMask,
  output logic                           nmiOut,
  output logic [NUM_LINES-1:0]           rdData
);

  logic [NUM_LINES-1:0] irqPrev;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] setMask, clrMask, ackMask, eoiMask;
  logic                 nmiEnQ;
  logic [ID_W-1:0]      nmiSelQ;

  assign rise    = irqIn & ~irqPrev;
  assign setMask = strobes.setPend ? wdata : '0;
  assign clrMask = strobes.clrPend ? wdata : '0;
  assign ackMask = strobes.ack ? (NUM_LINES'(1) << ackId) : '0;
  assign eoiMask = strobes.eoi ? (NUM_LINES'(1) << eoiId) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev <= '0;
      enQ     <= '0;
      pendQ   <= '0;
      actQ    <= '0;
    end else begin
      irqPrev <= irqIn;
      if (strobes.setEn)      enQ <= enQ | wdata;
      else if (strobes.clrEn) enQ <= enQ & ~wdata;
      // hardware edge is applied last so it survives any removal (R11)
      pendQ <= ((pendQ | setMask) & ~clrMask & ~ackMask) | rise;
      // acknowledge overrides end-of-service on the same line (R10)
      actQ  <= (actQ & ~eoiMask) | ackMask;
    end
  end

  // priority fields, one register per line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    localparam int WIDX = i / LPW;
    localparam int BOFF = (i % LPW) * PRIO_BITS;
    logic [PRIO_BITS-1:0] prioQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ <= '0;
      end else if (strobes.prioWr && strobes.prioWord == PRIO_WORD_W'(WIDX)) begin
        prioQ <= wdata[BOFF +: PRIO_BITS];
      end
    end
    assign prioFlat[i*PRIO_BITS +: PRIO_BITS] = prioQ;
  end

  // non-maskable selection and its registered output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiEnQ  <= 1'b0;
      nmiSelQ <= '0;
      nmiOut  <= 1'b0;
    end else begin
      nmiOut <= nmiEnQ && irqIn[nmiSelQ];
      if (strobes.nmiWr) begin
        nmiEnQ  <= wdata[ID_W];
        nmiSelQ <= wdata[ID_W-1:0];
      end
    end
  end

  assign nmiLineMask = nmiEnQ ? (NUM_LINES'(1) << nmiSelQ) : '0;

  // register read-back
  always_comb begin
    rdData = '0;
    case (busAddr)
      ADDR_W'(0), ADDR_W'(1): rdData = enQ;
      ADDR_W'(2), ADDR_W'(3): rdData = pendQ;
      ADDR_W'(4):             rdData = actQ;
      ADDR_W'(NMI_ADDR): begin
        rdData[ID_W]     = nmiEnQ;
        rdData[ID_W-1:0] = nmiSelQ;
      end
      default: begin
        for (int w = 0; w < PRIO_WORDS; w++) begin
          if (busAddr == ADDR_W'(PRIO_BASE + w)) begin
            for (int k = 0; k < LPW; k++) begin
              if (w * LPW + k < NUM_LINES) begin
                rdData[k*PRIO_BITS +: PRIO_BITS] = prioFlat[(w*LPW + k)*PRIO_BITS +: PRIO_BITS];
              end
            end
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/irq_ctrl_arbiter.sv
module irq_ctrl_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  localparam int ID_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]           pendQ,
  input  logic [NUM_LINES-1:0]           enQ,
  input  logic [NUM_LINES-1:0]           excludeMask,
  input  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat,
  input  logic [PRIO_BITS:0]             prioMask,
  input  logic                           nmiOut,
  output logic                           irqReq,
  output logic [ID_W-1:0]                irqId
);

  logic                 found;
  logic [PRIO_BITS-1:0] bestPrio;
  logic [ID_W-1:0]      bestId;
  logic [PRIO_BITS-1:0] curPrio;
  logic                 cand;

  always_comb begin
    found    = 1'b0;
    bestPrio = '1;
    bestId   = '0;
    curPrio  = '0;
    cand     = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      curPrio = prioFlat[i*PRIO_BITS +: PRIO_BITS];
      cand    = pendQ[i] && enQ[i] && !excludeMask[i] && ({1'b0, curPrio} < prioMask);
      // strict compare keeps the lower-numbered line on a tie
      if (cand && (!found || curPrio < bestPrio)) begin
        found    = 1'b1;
        bestPrio = curPrio;
        bestId   = ID_W'(i);
      end
    end
  end

  assign irqReq = found && !nmiOut;
  assign irqId  = bestId;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 4,
  localparam int ID_W     = $clog2(NUM_LINES),
  localparam int LPW      = NUM_LINES / PRIO_BITS,
  localparam int PRIO_WORDS = (NUM_LINES + LPW - 1) / LPW,
  localparam int PRIO_BASE  = 5,
  localparam int NMI_ADDR   = PRIO_BASE + PRIO_WORDS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [PRIO_BITS:0]   prioMask,
  output logic                 irqReq,
  output logic [ID_W-1:0]      irqId,
  input  logic                 irqAck,
  input  logic                 eoiValid,
  input  logic [ID_W-1:0]      eoiId,
  output logic                 nmiOut
);

  ctrlStrobes_t                   strobes;
  logic [NUM_LINES-1:0]           enQ, pendQ, actQ, nmiLineMask;
  logic [NUM_LINES*PRIO_BITS-1:0] prioFlat;

  irq_ctrl_ctrl #(
    .ADDR_W(ADDR_W), .PRIO_BASE(PRIO_BASE), .PRIO_WORDS(PRIO_WORDS), .NMI_ADDR(NMI_ADDR)
  ) u_ctrl (
    .busWr(busWr), .busAddr(busAddr), .irqAck(irqAck), .irqReq(irqReq),
    .eoiValid(eoiValid), .strobes(strobes)
  );

  irq_ctrl_datapath #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W),
    .PRIO_BASE(PRIO_BASE), .NMI_ADDR(NMI_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata), .busAddr(busAddr),
    .irqIn(irqIn), .ackId(irqId), .eoiId(eoiId), .enQ(enQ), .pendQ(pendQ),
    .actQ(actQ), .prioFlat(prioFlat), .nmiLineMask(nmiLineMask), .nmiOut(nmiOut),
    .rdData(busRdata)
  );

  irq_ctrl_arbiter #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)
  ) u_arb (
    .pendQ(pendQ), .enQ(enQ), .excludeMask(nmiLineMask), .prioFlat(prioFlat),
    .prioMask(prioMask), .nmiOut(nmiOut), .irqReq(irqReq), .irqId(irqId)
  );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 4,
  localparam int ID_W     = $clog2(NUM_LINES)
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           irqReq,
  input logic [ID_W-1:0]                irqId,
  input logic                           irqAck,
  input logic                           eoiValid,
  input logic [ID_W-1:0]                eoiId,
  input logic                           nmiOut,
  input logic [PRIO_BITS:0]             prioMask,
  input logic                           busWr,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [NUM_LINES-1:0]           pendQ,
  input logic [NUM_LINES-1:0]           enQ,
  input logic [NUM_LINES-1:0]           actQ,
  input logic [NUM_LINES*PRIO_BITS-1:0] prioFlat
);

  // R6
  req_is_candidate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendQ[irqId] && enQ[irqId]));

  // R8
  req_under_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ({1'b0, prioFlat[irqId*PRIO_BITS +: PRIO_BITS]} < prioMask));

  // R12
  nmi_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |-> !irqReq);

  // R9
  ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> actQ[$past(irqId)]);

  // R10
  eoi_clears_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && !(irqAck && irqReq && irqId == eoiId)) |=> !actQ[$past(eoiId)]);

  // R5
  active_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(4) && !eoiValid && !(irqAck && irqReq)) |=> $stable(actQ));

endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqId(irqId), .irqAck(irqAck),
  .eoiValid(eoiValid), .eoiId(eoiId), .nmiOut(nmiOut), .prioMask(prioMask),
  .busWr(busWr), .busAddr(busAddr), .pendQ(pendQ), .enQ(enQ), .actQ(actQ),
  .prioFlat(prioFlat)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  busAddr;
  logic        busWr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [31:0] irqIn;
  logic [2:0]  prioMask;
  logic        irqReq;
  logic [4:0]  irqId;
  logic        irqAck;
  logic        eoiValid;
  logic [4:0]  eoiId;
  logic        nmiOut;

  always #4 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqIn(irqIn), .prioMask(prioMask), .irqReq(irqReq),
    .irqId(irqId), .irqAck(irqAck), .eoiValid(eoiValid), .eoiId(eoiId), .nmiOut(nmiOut)
  );

  int checks = 0;
  int fails  = 0;
  bit cmpOn  = 1'b0;

  task automatic check(string tag, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] mEn, mPend, mAct, mPrev;
  int        mPrio [32];
  bit        mNmiEn;
  int        mNmiSel;
  bit        mNmiOut;

  function automatic void expOut(output bit req, output int id);
    int best;
    req  = 1'b0;
    id   = 0;
    best = 99;
    for (int i = 0; i < 32; i++) begin
      if (mPend[i] && mEn[i] && !(mNmiEn && mNmiSel == i) && mPrio[i] < int'(prioMask)
          && mPrio[i] < best) begin
        best = mPrio[i];
        id   = i;
        req  = 1'b1;
      end
    end
    if (mNmiOut) req = 1'b0;
  endfunction

  function automatic logic [31:0] expRead(int a);
    logic [31:0] r;
    r = '0;
    case (a)
      0, 1: r = mEn;
      2, 3: r = mPend;
      4:    r = mAct;
      5, 6: for (int k = 0; k < 16; k++) r[2*k +: 2] = 2'(mPrio[(a-5)*16 + k]);
      7:    r = {26'd0, mNmiEn, 5'(mNmiSel)};
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit        r;
    int        id;
    bit [31:0] rise;
    if (!rstN) begin
      mEn = '0; mPend = '0; mAct = '0; mPrev = '0;
      for (int i = 0; i < 32; i++) mPrio[i] = 0;
      mNmiEn = 1'b0; mNmiSel = 0; mNmiOut = 1'b0;
    end else begin
      expOut(r, id);
      rise    = irqIn & ~mPrev;
      mNmiOut = mNmiEn && irqIn[mNmiSel];
      if (busWr) begin
        case (int'(busAddr))
          0: mEn   = mEn | busWdata;
          1: mEn   = mEn & ~busWdata;
          2: mPend = mPend | busWdata;
          3: mPend = mPend & ~busWdata;
          5, 6: for (int k = 0; k < 16; k++) mPrio[(int'(busAddr)-5)*16 + k] = int'(busWdata[2*k +: 2]);
          7: begin mNmiEn = busWdata[5]; mNmiSel = int'(busWdata[4:0]); end
          default: ;
        endcase
      end
      if (eoiValid) mAct[eoiId] = 1'b0;
      if (irqAck && r) begin
        mPend[id] = 1'b0;
        mAct[id]  = 1'b1;
      end
      mPend = mPend | rise;
      mPrev = irqIn;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    bit r;
    int id;
    if (cmpOn) begin
      expOut(r, id);
      check("R6 irqReq", 32'(irqReq), 32'(r));
      if (r) check("R7 irqId", 32'(irqId), 32'(id));
      check("R12 nmiOut", 32'(nmiOut), 32'(mNmiOut));
      check("R1 busRdata", busRdata, expRead(int'(busAddr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d);
    busWr = 1'b1; busAddr = 4'(a); busWdata = d;
    step();
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(int a, logic [31:0] expected, string tag);
    busAddr = 4'(a);
    #1;
    check(tag, busRdata, expected);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWr = 1'b0; busWdata = '0; irqIn = '0;
    prioMask = 3'd4; irqAck = 1'b0; eoiValid = 1'b0; eoiId = '0;
    step(); step(); step();
    // R13 reset state
    check("R13 irqReq", 32'(irqReq), 32'd0);
    check("R13 nmiOut", 32'(nmiOut), 32'd0);
    for (int a = 0; a < 8; a++) rd(a, 32'd0, "R13 register");
    rstN = 1'b1;
    cmpOn = 1'b1;
    step();

    // R1 set-enable, zero bits do nothing
    wr(0, 32'h0000_00F0);
    rd(0, 32'h0000_00F0, "R1 set enable");
    wr(0, 32'h0);
    rd(0, 32'h0000_00F0, "R1 zero write");
    rd(1, 32'h0000_00F0, "R1 read via clear address");

    // R2 clear-enable
    wr(1, 32'h0000_0010);
    rd(0, 32'h0000_00E0, "R2 clear enable");
    wr(1, 32'h0);
    rd(1, 32'h0000_00E0, "R2 zero write");

    // R4 edge latching on a disabled line
    irqIn[3] = 1'b1;
    step();
    rd(2, 32'h0000_0008, "R4 edge sets pending");
    check("R4 disabled line not presented", 32'(irqReq), 32'd0);
    wr(3, 32'h0000_0008);
    step();
    rd(2, 32'h0, "R4 held level does not re-pend");
    irqIn[3] = 1'b0;
    step();

    // R3 software pending
    wr(2, 32'h0000_0020);
    rd(3, 32'h0000_0020, "R3 set pending");
    check("R3 request", 32'(irqReq), 32'd1);
    check("R3 id", 32'(irqId), 32'd5);
    wr(3, 32'h0000_0020);
    rd(2, 32'h0, "R3 clear pending");
    check("R3 request gone", 32'(irqReq), 32'd0);

    // R6/R7 priority and tie break: line5=2, line6=1, line7=1
    wr(5, 32'h0000_5800);
    rd(5, 32'h0000_5800, "R6 priority word");
    wr(2, 32'h0000_00E0);
    check("R6 request", 32'(irqReq), 32'd1);
    check("R7 lowest number wins tie", 32'(irqId), 32'd6);

    // R8 mask
    prioMask = 3'd1; #1;
    check("R8 mask blocks", 32'(irqReq), 32'd0);
    prioMask = 3'd2; #1;
    check("R8 mask passes", 32'(irqReq), 32'd1);
    check("R8 id", 32'(irqId), 32'd6);
    prioMask = 3'd0; #1;
    check("R8 mask zero", 32'(irqReq), 32'd0);
    prioMask = 3'd4;
    step();

    // R9 acknowledge
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    rd(2, 32'h0000_00A0, "R9 pending cleared");
    rd(4, 32'h0000_0040, "R9 active set");
    check("R9 next line", 32'(irqId), 32'd7);

    // R5 active is read only
    wr(4, 32'hFFFF_FFFF);
    rd(4, 32'h0000_0040, "R5 write ignored");

    // R10 end of service, then ack and eoi together on line 7
    eoiValid = 1'b1; eoiId = 5'd6;
    step();
    eoiValid = 1'b0;
    rd(4, 32'h0, "R10 eoi clears");
    irqAck = 1'b1; eoiValid = 1'b1; eoiId = 5'd7;
    step();
    irqAck = 1'b0; eoiValid = 1'b0;
    rd(4, 32'h0000_0080, "R10 ack wins over eoi");
    eoiValid = 1'b1;
    step();
    eoiValid = 1'b0;
    rd(4, 32'h0, "R10 eoi line 7");

    // R11 edge coincides with acknowledge
    check("R11 id before ack", 32'(irqId), 32'd5);
    irqAck = 1'b1; irqIn[5] = 1'b1;
    step();
    irqAck = 1'b0;
    rd(2, 32'h0000_0020, "R11 edge beats ack");
    rd(4, 32'h0000_0020, "R11 active after ack");
    irqIn[5] = 1'b0;
    step();
    // R11 edge coincides with clear-pending write
    irqIn[5] = 1'b1;
    wr(3, 32'h0000_0020);
    rd(2, 32'h0000_0020, "R11 edge beats clear");
    irqIn[5] = 1'b0;
    wr(3, 32'h0000_0020);
    eoiValid = 1'b1; eoiId = 5'd5;
    step();
    eoiValid = 1'b0;

    // R12 non-maskable routing of line 9
    wr(7, 32'h0000_0029);
    rd(7, 32'h0000_0029, "R12 selection readback");
    wr(0, 32'h0000_0200);
    wr(2, 32'h0000_0040);
    check("R12 normal request", 32'(irqReq), 32'd1);
    irqIn[9] = 1'b1;
    step();
    check("R12 nmi high", 32'(nmiOut), 32'd1);
    check("R12 request blocked", 32'(irqReq), 32'd0);
    irqIn[9] = 1'b0;
    step();
    check("R12 nmi low", 32'(nmiOut), 32'd0);
    rd(2, 32'h0000_0240, "R12 pending latched");
    check("R12 selected line excluded", 32'(irqId), 32'd6);
    wr(3, 32'h0000_0040);
    check("R12 only selected line left", 32'(irqReq), 32'd0);
    wr(7, 32'h0);
    check("R12 released line presented", 32'(irqReq), 32'd1);
    check("R12 released id", 32'(irqId), 32'd9);
    wr(3, 32'h0000_0200);

    // randomised phase against the model
    for (int c = 0; c < 3000; c++) begin
      busWr    = ($urandom_range(0, 9) < 3);
      busAddr  = 4'($urandom_range(0, 8));
      busWdata = $urandom() & $urandom();
      if ($urandom_range(0, 3) == 0) irqIn = irqIn ^ (32'd1 << $urandom_range(0, 31));
      irqAck   = ($urandom_range(0, 4) == 0);
      eoiValid = ($urandom_range(0, 9) == 0);
      eoiId    = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) prioMask = 3'($urandom_range(0, 4));
      step();
    end
    busWr = 1'b0; irqAck = 1'b0; eoiValid = 1'b0;
    step();
    cmpOn = 1'b0;
    finishRun();
  end

endmodule